// File: doc/BRIEF.md
# AES Key-Schedule Step Unit

This unit carries out one forward key-expansion step of AES for a 64-bit scalar cryptography instruction. It is purely combinational. It takes the raw 32-bit instruction word and the 64-bit source operand. It decodes the word to confirm the instruction and to extract a 4-bit round selector. It then passes the upper word of the operand through four forward AES substitution boxes. For ordinary rounds it rotates the substituted word and mixes in a round constant. The 32-bit step value is returned in both halves of the 64-bit result.

Round selector 10 serves the AES-256 schedule. In that round the substituted word is returned as it is, with no rotation and no constant. Selector values above 10 are not accepted as this instruction. The unit is only meaningful at a 64-bit datapath width, and an elaboration at any other width never reports a match. When there is no match, the result and the register-index outputs are forced to zero.

Top module: `ks_step_unit`

## Requirements
- R1: The word matches only when all of these hold: bits 31:30 = 00, bits 29:25 = 11000, bit 24 = 1, bits 14:12 = 001 and bits 6:0 = 0010011. The round selector is bits 23:20.
- R2: A selector value of 0xB to 0xF gives valid_o = 0, even when every fixed field matches.
- R3: Bits 31:0 of the source operand have no effect on the result. Only bits 63:32 are used.
- R4: Each of the four bytes of the upper source word goes through the forward AES S-box, byte lane to byte lane.
- R5: With selector 0xA, the 32-bit step value equals the substituted word, with no rotation and no constant.
- R6: With selectors 0x0 to 0x9, the substituted word is rotated right by 8 bits, so byte 0 moves to byte 3. The round constant is then XORed in.
- R7: The round constant for selectors 0 to 9 is 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B and 0x36 respectively. It sits in bits 7:0, and bits 31:8 are zero.
- R8: result_o holds the 32-bit step value in both bits 63:32 and bits 31:0.
- R9: When valid_o = 0, result_o, rs1_o and rd_o are all zero.
- R10: An elaboration with XLEN other than 64 never asserts valid_o.
- R11: On a match, rs1_o carries bits 19:15 of the word and rd_o carries bits 11:7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 32 | Instruction word to decode |
| src_i | input | XLEN | Source operand; only the upper word is used |
| valid_o | output | 1 | Word is this instruction with a legal selector |
| rs1_o | output | 5 | Source register index, zero when not valid |
| rd_o | output | 5 | Destination register index, zero when not valid |
| result_o | output | XLEN | Step value duplicated into both halves, zero when not valid |

## Verification
The S-boxes are the hardest part to observe completely. In ordinary rounds their output is rotated and then mixed with a constant, so an error in one lane can look like an error in another. The stimulus therefore uses selector 0xA to see the substitution directly. It sweeps all 256 byte values through every lane at once, with each lane offset from its neighbour. A second model of the S-box in the bench computes the expected values. It finds the field inverse by search and applies the affine map bit by bit. Illegal selectors are tried with every fixed field correct, so that only the selector check can cause the rejection.

// File: rtl/ks_pkg.sv
package ks_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int RNUM_W = 4;
    localparam int REG_W  = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [RNUM_W-1:0] rnum_t;
    typedef logic [REG_W-1:0]  regidx_t;

    localparam rnum_t RNUM_FINAL = 4'hA;

    // fixed fields of the instruction word
    localparam logic [1:0] F_TOP    = 2'b00;
    localparam logic [4:0] F_GROUP  = 5'b11000;
    localparam logic       F_SEL    = 1'b1;
    localparam logic [2:0] F_FUNCT3 = 3'b001;
    localparam logic [6:0] F_OPCODE = 7'b0010011;

    typedef struct packed {
        logic    valid;
        rnum_t   rnum;
        regidx_t rs1;
        regidx_t rd;
    } ks_dec_t;

    function automatic byte_t gf_xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc = '0;
        byte_t sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // x^254 in the field; maps zero to zero
    function automatic byte_t gf_inv(byte_t x);
        byte_t sq  = x;
        byte_t acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    function automatic byte_t rotl8(byte_t v, int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_fwd(byte_t x);
        byte_t b = gf_inv(x);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

    function automatic word_t rcon_of(rnum_t r);
        byte_t c = 8'h01;
        for (int i = 0; i < 9; i++) begin
            if (i < int'(r)) c = gf_xtime(c);
        end
        return {{(WORD_W-BYTE_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/ks_insn_decode.sv
module ks_insn_decode
    import ks_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0] insn_i,
    output ks_dec_t     dec_o
);
    localparam bit WIDTH_OK = (XLEN == 2 * WORD_W);

    logic  fields_ok;
    rnum_t rnum;

    always_comb begin
        rnum      = insn_i[23:20];
        fields_ok = (insn_i[31:30] == F_TOP)
                 && (insn_i[29:25] == F_GROUP)
                 && (insn_i[24]    == F_SEL)
                 && (insn_i[14:12] == F_FUNCT3)
                 && (insn_i[6:0]   == F_OPCODE);
        dec_o.valid = WIDTH_OK && fields_ok && (rnum <= RNUM_FINAL);
        dec_o.rnum  = rnum;
        dec_o.rs1   = insn_i[19:15];
        dec_o.rd    = insn_i[11:7];
    end
endmodule

// File: rtl/ks_sbox_byte.sv
module ks_sbox_byte
    import ks_pkg::*;
(
    input  byte_t in_i,
    output byte_t out_o
);
    always_comb begin
        out_o = sbox_fwd(in_i);
        AST_SBOX_NO_FIXED: assert ((out_o != in_i) && (out_o != ~in_i))
            else $error("sbox fixed point at %02h", in_i); // R4
    end
endmodule

// File: rtl/ks_subword.sv
module ks_subword
    import ks_pkg::*;
(
    input  word_t word_i,
    output word_t word_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        ks_sbox_byte u_sbox (
            .in_i  (word_i[g*BYTE_W +: BYTE_W]),
            .out_o (word_o[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/ks_round_mix.sv
module ks_round_mix
    import ks_pkg::*;
(
    input  rnum_t rnum_i,
    input  word_t sub_i,
    output word_t word_o
);
    word_t rotated;

    always_comb begin
        rotated = {sub_i[BYTE_W-1:0], sub_i[WORD_W-1:BYTE_W]};
        if (rnum_i == RNUM_FINAL) word_o = sub_i;
        else                      word_o = rotated ^ rcon_of(rnum_i);
    end
endmodule

// File: rtl/ks_step_unit.sv
module ks_step_unit
    import ks_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] src_i,
    output logic            valid_o,
    output logic [4:0]      rs1_o,
    output logic [4:0]      rd_o,
    output logic [XLEN-1:0] result_o
);
    ks_dec_t dec;
    word_t   prev_w, sub_w, step_w;

    ks_insn_decode #(.XLEN(XLEN)) u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    if (XLEN == 2 * WORD_W) begin : g_wide
        assign prev_w = src_i[XLEN-1 -: WORD_W];
        always_comb result_o = dec.valid ? {step_w, step_w} : '0;
    end else begin : g_narrow
        logic unused_src;
        assign unused_src = ^src_i;
        assign prev_w     = '0;
        always_comb result_o = '0;
    end

    ks_subword u_sub (
        .word_i (prev_w),
        .word_o (sub_w)
    );

    ks_round_mix u_mix (
        .rnum_i (dec.rnum),
        .sub_i  (sub_w),
        .word_o (step_w)
    );

    always_comb begin
        valid_o = dec.valid;
        rs1_o   = dec.valid ? dec.rs1 : '0;
        rd_o    = dec.valid ? dec.rd  : '0;
    end

    always_comb begin
        if (valid_o) begin
            AST_RNUM_LEGAL: assert (dec.rnum <= RNUM_FINAL)
                else $error("accepted selector %0h", dec.rnum); // R2
            if (dec.rnum != RNUM_FINAL) begin
                AST_ROTATED_UPPER: assert (result_o[31:8] == {sub_w[7:0], sub_w[31:16]})
                    else $error("rotation mismatch"); // R6
            end
        end else begin
            AST_ZERO_WHEN_INVALID: assert ((result_o == '0) && (rs1_o == '0) && (rd_o == '0))
                else $error("outputs not cleared"); // R9
        end
    end
endmodule

// File: tb/ks_step_unit_tb.sv
module ks_step_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [31:0] insn;
    logic [63:0] src;
    logic        valid;
    logic [4:0]  rs1, rd;
    logic [63:0] result;
    logic [31:0] src32;
    logic        valid32;
    logic [4:0]  rs1_32, rd_32;
    logic [31:0] result32;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    ks_step_unit #(.XLEN(64)) u_dut (
        .insn_i(insn), .src_i(src), .valid_o(valid),
        .rs1_o(rs1), .rd_o(rd), .result_o(result)
    );

    ks_step_unit #(.XLEN(32)) u_dut32 (
        .insn_i(insn), .src_i(src32), .valid_o(valid32),
        .rs1_o(rs1_32), .rd_o(rd_32), .result_o(result32)
    );

    function automatic logic [31:0] mk(logic [3:0] r, logic [4:0] s1, logic [4:0] d);
        return {2'b00, 5'b11000, 1'b1, r, s1, 3'b001, d, 7'b0010011};
    endfunction

    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        logic [7:0] y = b;
        while (y != 0) begin
            if (y[0]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
            y = y >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sbox(logic [7:0] x);
        logic [7:0] b = 0;
        logic [7:0] s;
        for (int y = 1; y < 256; y++)
            if (m_mul(x, 8'(y)) == 8'h01) b = 8'(y);
        for (int i = 0; i < 8; i++)
            s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
        return s ^ 8'h63;
    endfunction

    function automatic logic [31:0] m_rcon(logic [3:0] r);
        case (r)
            4'h0: return 32'h01;  4'h1: return 32'h02;
            4'h2: return 32'h04;  4'h3: return 32'h08;
            4'h4: return 32'h10;  4'h5: return 32'h20;
            4'h6: return 32'h40;  4'h7: return 32'h80;
            4'h8: return 32'h1B;  4'h9: return 32'h36;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [63:0] m_step(logic [3:0] r, logic [63:0] s);
        logic [31:0] w = s[63:32];
        logic [31:0] sw, o;
        for (int i = 0; i < 4; i++) sw[i*8 +: 8] = m_sbox(w[i*8 +: 8]);
        if (r == 4'hA) o = sw;
        else           o = {sw[7:0], sw[31:8]} ^ m_rcon(r);
        return {o, o};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] i, logic [63:0] s);
        @(negedge clk);
        insn  = i;
        src   = s;
        src32 = s[63:32];
        #1;
    endtask

    task automatic t_reset;
        apply(32'h0, 64'h0);
        chk("R9 reset valid", {63'b0, valid}, 64'h0);
        chk("R9 reset result", result, 64'h0);
    endtask

    task automatic t_known;
        apply(mk(4'h0, 5'd3, 5'd9), 64'h0);
        chk("R6 zero word round0", result, 64'h63636362_63636362);
        chk("R1 valid", {63'b0, valid}, 64'h1);
        chk("R11 rs1", {59'b0, rs1}, 64'd3);
        chk("R11 rd", {59'b0, rd}, 64'd9);
        apply(mk(4'hA, 5'd1, 5'd2), 64'h0);
        chk("R5 zero word final", result, 64'h63636363_63636363);
        apply(mk(4'hA, 5'd1, 5'd2), 64'h00_01_53_FF_0000_0000);
        chk("R4 spot bytes", result, 64'h637CED16_637CED16);
        apply(mk(4'h3, 5'd1, 5'd2), 64'h00_01_53_FF_0000_0000);
        chk("R6 rotate spot", result, {32'h16637CED ^ 32'h08, 32'h16637CED ^ 32'h08});
    endtask

    task automatic t_rounds;
        for (int r = 0; r <= 10; r++) begin
            apply(mk(4'(r), 5'd7, 5'd8), 64'h0);
            chk("R7 rcon zero word", result, m_step(4'(r), 64'h0));
            for (int k = 0; k < 6; k++) begin
                logic [63:0] s = {$urandom, $urandom};
                apply(mk(4'(r), 5'd7, 5'd8), s);
                chk(r == 10 ? "R5 random" : "R6 random", result, m_step(4'(r), s));
                chk("R8 halves", {32'b0, result[63:32]}, {32'b0, result[31:0]});
            end
        end
    endtask

    task automatic t_sweep;
        for (int b = 0; b < 256; b++) begin
            logic [31:0] w = {8'(b), 8'(b+85), 8'(b+170), 8'(b+37)};
            apply(mk(4'hA, 5'd0, 5'd0), {w, 32'h0});
            chk("R4 lane sweep", result, m_step(4'hA, {w, 32'h0}));
        end
    endtask

    task automatic t_low_ignored;
        logic [63:0] base = {$urandom, 32'h0};
        logic [63:0] ref_r;
        apply(mk(4'h5, 5'd4, 5'd4), base);
        ref_r = result;
        for (int k = 0; k < 4; k++) begin
            apply(mk(4'h5, 5'd4, 5'd4), {base[63:32], $urandom});
            chk("R3 low half ignored", result, ref_r);
        end
    endtask

    task automatic t_illegal;
        for (int r = 11; r < 16; r++) begin
            apply(mk(4'(r), 5'd5, 5'd6), {$urandom, $urandom});
            chk("R2 illegal selector", {63'b0, valid}, 64'h0);
            chk("R9 cleared result", result, 64'h0);
            chk("R9 cleared regs", {54'b0, rs1, rd}, 64'h0);
        end
    endtask

    task automatic t_bad_fields;
        int pos [15] = '{31, 30, 29, 28, 27, 26, 25, 24, 14, 13, 12, 6, 4, 1, 0};
        foreach (pos[k]) begin
            apply(mk(4'h2, 5'd1, 5'd1) ^ (32'h1 << pos[k]), 64'hFFFF_FFFF_0000_0000);
            chk("R1 fixed field bit", {63'b0, valid}, 64'h0);
        end
    endtask

    task automatic t_width;
        apply(mk(4'h1, 5'd2, 5'd3), {$urandom, $urandom});
        chk("R10 narrow never valid", {63'b0, valid32}, 64'h0);
        chk("R10 narrow zero result", {32'b0, result32}, 64'h0);
    endtask

    initial begin
        insn = '0; src = '0; src32 = '0;
        repeat (2) @(posedge clk);
        t_reset();
        rst = 1'b0;
        t_known();
        t_rounds();
        t_sweep();
        t_low_ignored();
        t_illegal();
        t_bad_fields();
        t_width();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule